// File: doc/BRIEF.md
# Multidrop Receive Buffer Controller

This block sits after a UART character receiver and files the received characters into a ring of receive buffers. Each character arrives as a one-cycle strobe with its data byte and four qualifiers: address, break, framing error and parity error. The block writes the accepted bytes through a byte write port into a shared buffer memory. For each buffer it keeps an ownership bit, a set of status flags and a byte count, and it pulses a per-buffer close line when it hands a buffer back.

The block has three operating modes. Plain mode stores every character. Manual multidrop mode stores address characters and starts a new buffer at each one. Automatic multidrop mode compares each address character against two programmable addresses and accepts data only after a match. It does not store the address itself, and it records which of the two addresses matched.

A buffer closes in any of these cases: it fills; a programmable number of consecutive idle sequences arrives while it holds data; a framing or parity error is stored; a break is seen; or a new message begins. In continuous mode a buffer that closes cleanly stays owned by the receiver, so it is reused on the next pass around the ring.

Top module: `mdrop_rx_bufctl`

## Requirements
- R1: Buffers are filled in ring order 0,1,2,3,0,… Each stored byte is written one cycle after its strobe, at memory address buffer*16 + offset, with offsets starting at 0. In plain mode (mode 0) every character that is not a break is stored.
- R2: Storing the 16th byte closes the buffer. This pulses its close line, clears its ownership (empty) bit when not in continuous mode, and leaves the count at 16 with no flags set.
- R3: While a buffer holds data, each idle strobe advances a counter and any character clears it. When the counter reaches idle_limit, the buffer closes with the idle flag set (flag bit 5).
- R4: A character with a framing error is stored as the last byte. Flag bit 2 is set, the buffer closes, and the next character goes to the next buffer.
- R5: A character with a parity error is stored as the last byte. Flag bit 1 is set, the buffer closes, and the next character goes to the next buffer.
- R6: A break strobe while the current buffer holds data is not stored. It sets flag bit 3 and closes the buffer. A break strobe while the current buffer is empty of data has no effect.
- R7: When a character would be stored into a buffer whose empty bit is 0, it is dropped. Flag bit 0 (overrun) is then set in the most recently closed buffer.
- R8: In continuous mode a clean close (full, idle or message boundary) leaves the empty bit at 1. A close caused by a framing error, a parity error or a break clears it.
- R9: In manual mode (mode 1) an address character is stored. If the current buffer holds data, that buffer closes first and the address becomes byte 0 of the next buffer. A buffer whose byte 0 is an address has flag bit 6 set.
- R10: In automatic mode (mode 2) address characters are never stored, and any address character closes a buffer that holds data. Data is stored only while the last address matched addr_a or addr_b; otherwise it is dropped.
- R11: In automatic mode the first buffer filled after a match has flag bit 6 set. Its flag bit 4 is 1 if addr_a matched and 0 if addr_b matched.
- R12: A pulse on buf_arm[i] sets empty bit i and clears that buffer's flags and count.
- R13: After reset all empty bits, flags, counts, close pulses and memory writes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | 0 plain, 1 manual multidrop, 2 automatic multidrop, 3 plain |
| cont_mode | input | 1 | Keep ownership on clean closes |
| addr_a | input | 8 | First match address (flag bit 4 = 1) |
| addr_b | input | 8 | Second match address (flag bit 4 = 0) |
| idle_limit | input | 16 | Consecutive idle strobes that close a buffer |
| ch_valid | input | 1 | Character strobe |
| ch_data | input | 8 | Character byte |
| ch_addr | input | 1 | Character is an address |
| ch_brk | input | 1 | Strobe is a break condition |
| ch_ferr | input | 1 | Character lacks its stop bit |
| ch_perr | input | 1 | Character failed parity |
| idle_tick | input | 1 | One idle sequence received |
| buf_arm | input | 4 | Hand buffer i to the receiver |
| mem_we | output | 1 | Buffer memory write enable |
| mem_addr | output | 6 | Buffer memory byte address |
| mem_wdata | output | 8 | Buffer memory write data |
| buf_empty | output | 4 | Per-buffer ownership bit |
| buf_flags | output | 28 | Seven flags per buffer, buffer i at bits 7i+6..7i |
| buf_len | output | 20 | Five-bit byte count per buffer |
| buf_close | output | 4 | One-cycle close pulse per buffer |

## Verification
Plain runs of characters interleaved with idle strobes show whether a character really restarts the idle count or whether idles are merely summed. Runs that end in a framing error, a parity error, a break or a 16th byte separate the four close causes by their flag bits and by where the next byte lands. The same runs repeated in continuous mode show which closes keep ownership. Address sequences in the two multidrop modes contrast storing against stripping the address, separate a match on the first address from a match on the second, and check that data after an unmatched address is dropped.

// File: rtl/mdrop_rx_pkg.sv
package mdrop_rx_pkg;

   typedef enum logic [1:0] {
      RXM_PLAIN  = 2'd0,
      RXM_MANUAL = 2'd1,
      RXM_AUTO   = 2'd2,
      RXM_SPARE  = 2'd3
   } rx_mode_e;

   // bit 6 .. bit 0
   typedef struct packed {
      logic addr;
      logic idle;
      logic am;
      logic brk;
      logic fr;
      logic pr;
      logic ov;
   } rx_flags_t;

   localparam int unsigned FLAG_W = $bits(rx_flags_t);

endpackage

// File: rtl/mdrop_rx_filter.sv
module mdrop_rx_filter
   import mdrop_rx_pkg::*;
#(
   parameter int DW        = 8,
   parameter bit MULTIDROP = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    mode,
   input  logic [DW-1:0] addr_a,
   input  logic [DW-1:0] addr_b,
   input  logic          ch_valid,
   input  logic [DW-1:0] ch_data,
   input  logic          ch_addr,
   input  logic          ch_brk,
   output logic          store,
   output logic          boundary,
   output logic          tag_addr,
   output logic          tag_am
);

   generate
      if (MULTIDROP) begin : g_md
         rx_mode_e md;
         logic     accept_q, pend_q, am_q;
         logic     hit_a, hit_b, chr;

         assign md    = rx_mode_e'(mode);
         assign hit_a = (ch_data == addr_a);
         assign hit_b = (ch_data == addr_b);
         assign chr   = ch_valid && !ch_brk;

         always_comb begin
            store    = 1'b0;
            boundary = 1'b0;
            tag_addr = 1'b0;
            tag_am   = 1'b0;
            if (chr) begin
               case (md)
                  RXM_MANUAL: begin
                     store    = 1'b1;
                     boundary = ch_addr;
                     tag_addr = ch_addr;
                  end
                  RXM_AUTO: begin
                     if (ch_addr) begin
                        boundary = 1'b1;
                     end else if (accept_q) begin
                        store    = 1'b1;
                        tag_addr = pend_q;
                        tag_am   = pend_q && am_q;
                     end
                  end
                  default: store = 1'b1;
               endcase
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               accept_q <= 1'b0;
               pend_q   <= 1'b0;
               am_q     <= 1'b0;
            end else if (md != RXM_AUTO) begin
               accept_q <= 1'b0;
               pend_q   <= 1'b0;
            end else if (chr) begin
               if (ch_addr) begin
                  accept_q <= hit_a || hit_b;
                  pend_q   <= hit_a || hit_b;
                  am_q     <= hit_a;
               end else if (accept_q) begin
                  pend_q   <= 1'b0;
               end
            end
         end
      end else begin : g_plain
         logic unused;
         assign unused   = ^{clk, rst_n, mode, addr_a, addr_b, ch_data, ch_addr};
         assign store    = ch_valid && !ch_brk;
         assign boundary = 1'b0;
         assign tag_addr = 1'b0;
         assign tag_am   = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/mdrop_rx_idle.sv
module mdrop_rx_idle #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] limit,
   input  logic          tick,
   input  logic          ch_valid,
   input  logic          active,
   output logic          hit
);

   logic [CW-1:0] cnt_q;
   logic [CW:0]   cnt_inc;

   assign cnt_inc = {1'b0, cnt_q} + 1'b1;
   assign hit     = active && tick && !ch_valid && (limit != '0)
                    && (cnt_inc == {1'b0, limit});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cnt_q <= '0;
      else if (!active || ch_valid || hit) cnt_q <= '0;
      else if (tick)                       cnt_q <= cnt_inc[CW-1:0];
   end

endmodule

// File: rtl/mdrop_rx_ring.sv
module mdrop_rx_ring
   import mdrop_rx_pkg::*;
#(
   parameter int NBUF  = 4,
   parameter int DEPTH = 16,
   parameter int DW    = 8
) (
   input  logic                                     clk,
   input  logic                                     rst_n,
   input  logic                                     cont_mode,
   input  logic                                     store,
   input  logic                                     boundary,
   input  logic                                     tag_addr,
   input  logic                                     tag_am,
   input  logic                                     brk_evt,
   input  logic                                     ferr,
   input  logic                                     perr,
   input  logic [DW-1:0]                            data,
   input  logic                                     idle_hit,
   input  logic [NBUF-1:0]                          arm,
   output logic                                     active,
   output logic                                     mem_we,
   output logic [$clog2(NBUF)+$clog2(DEPTH)-1:0]    mem_addr,
   output logic [DW-1:0]                            mem_wdata,
   output logic [NBUF-1:0]                          buf_empty,
   output logic [NBUF*FLAG_W-1:0]                   buf_flags,
   output logic [NBUF*$clog2(DEPTH+1)-1:0]          buf_len,
   output logic [NBUF-1:0]                          buf_close
);

   localparam int BW = $clog2(NBUF);
   localparam int OW = $clog2(DEPTH);
   localparam int LW = $clog2(DEPTH+1);
   localparam logic [OW-1:0] LAST = OW'(DEPTH-1);

   logic [BW-1:0] cur_q, cur_n, nxt, tgt, lastc;
   logic [OW-1:0] cnt_q, cnt_n, tgt_cnt;
   logic          pre_close, wr, wr_close, ovr, err_in, split;

   assign active    = (cnt_q != '0);
   assign nxt       = cur_q + 1'b1;
   assign split     = boundary && active;
   assign pre_close = active && (boundary || brk_evt || idle_hit);
   assign tgt       = split ? nxt : cur_q;
   assign tgt_cnt   = split ? '0  : cnt_q;
   assign lastc     = tgt - 1'b1;
   assign ovr       = store && !buf_empty[tgt];
   assign wr        = store && buf_empty[tgt];
   assign err_in    = ferr || perr;
   assign wr_close  = wr && ((tgt_cnt == LAST) || err_in);

   always_comb begin
      cur_n = cur_q;
      cnt_n = cnt_q;
      if (pre_close) begin
         cur_n = nxt;
         cnt_n = '0;
      end
      if (wr) begin
         if (wr_close) begin
            cur_n = tgt + 1'b1;
            cnt_n = '0;
         end else begin
            cur_n = tgt;
            cnt_n = tgt_cnt + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q     <= '0;
         cnt_q     <= '0;
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
      end else begin
         cur_q     <= cur_n;
         cnt_q     <= cnt_n;
         mem_we    <= wr;
         mem_addr  <= {tgt, tgt_cnt};
         mem_wdata <= data;
      end
   end

   for (genvar i = 0; i < NBUF; i++) begin : g_buf
      rx_flags_t     flags_q;
      logic [LW-1:0] len_q;
      logic          empty_q, close_q;
      logic          cl_pre, cl_wr, wr_i, ov_i, err_i, keep_i;

      assign cl_pre = pre_close && (cur_q == BW'(i));
      assign cl_wr  = wr_close && (tgt == BW'(i));
      assign wr_i   = wr && (tgt == BW'(i));
      assign ov_i   = ovr && (lastc == BW'(i));
      assign err_i  = (cl_pre && brk_evt) || (cl_wr && err_in);
      assign keep_i = cont_mode && !err_i;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flags_q <= '0;
            len_q   <= '0;
            empty_q <= 1'b0;
            close_q <= 1'b0;
         end else begin
            close_q <= (cl_pre || cl_wr) && !arm[i];
            if (arm[i]) begin
               flags_q <= '0;
               len_q   <= '0;
               empty_q <= 1'b1;
            end else begin
               if (wr_i) begin
                  if (tgt_cnt == '0) begin
                     flags_q      <= '0;
                     flags_q.addr <= tag_addr;
                     flags_q.am   <= tag_am;
                     len_q        <= LW'(1);
                  end else begin
                     len_q <= len_q + 1'b1;
                  end
                  if (ferr) flags_q.fr <= 1'b1;
                  if (perr) flags_q.pr <= 1'b1;
               end
               if (cl_pre && brk_evt)  flags_q.brk  <= 1'b1;
               if (cl_pre && idle_hit) flags_q.idle <= 1'b1;
               if (ov_i)               flags_q.ov   <= 1'b1;
               if (((cl_pre || cl_wr) && !keep_i) || ov_i) empty_q <= 1'b0;
            end
         end
      end

      assign buf_empty[i]                  = empty_q;
      assign buf_close[i]                  = close_q;
      assign buf_flags[i*FLAG_W +: FLAG_W] = flags_q;
      assign buf_len[i*LW +: LW]           = len_q;
   end

endmodule

// File: rtl/mdrop_rx_bufctl.sv
module mdrop_rx_bufctl
   import mdrop_rx_pkg::*;
#(
   parameter int NBUF      = 4,
   parameter int DEPTH     = 16,
   parameter int DW        = 8,
   parameter int IDLE_W    = 16,
   parameter bit MULTIDROP = 1'b1
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic [1:0]                            mode,
   input  logic                                  cont_mode,
   input  logic [DW-1:0]                         addr_a,
   input  logic [DW-1:0]                         addr_b,
   input  logic [IDLE_W-1:0]                     idle_limit,
   input  logic                                  ch_valid,
   input  logic [DW-1:0]                         ch_data,
   input  logic                                  ch_addr,
   input  logic                                  ch_brk,
   input  logic                                  ch_ferr,
   input  logic                                  ch_perr,
   input  logic                                  idle_tick,
   input  logic [NBUF-1:0]                       buf_arm,
   output logic                                  mem_we,
   output logic [$clog2(NBUF)+$clog2(DEPTH)-1:0] mem_addr,
   output logic [DW-1:0]                         mem_wdata,
   output logic [NBUF-1:0]                       buf_empty,
   output logic [NBUF*FLAG_W-1:0]                buf_flags,
   output logic [NBUF*$clog2(DEPTH+1)-1:0]       buf_len,
   output logic [NBUF-1:0]                       buf_close
);

   if (NBUF < 2 || (NBUF & (NBUF - 1)) != 0) begin : g_chk_nbuf
      $error("NBUF must be a power of two of at least 2");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_chk_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (DW < 1 || IDLE_W < 1) begin : g_chk_width
      $error("DW and IDLE_W must be positive");
   end

   logic store, boundary, tag_addr, tag_am, idle_hit, active, brk_evt;

   assign brk_evt = ch_valid && ch_brk;

   mdrop_rx_filter #(.DW(DW), .MULTIDROP(MULTIDROP)) u_filter (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .addr_a   (addr_a),
      .addr_b   (addr_b),
      .ch_valid (ch_valid),
      .ch_data  (ch_data),
      .ch_addr  (ch_addr),
      .ch_brk   (ch_brk),
      .store    (store),
      .boundary (boundary),
      .tag_addr (tag_addr),
      .tag_am   (tag_am)
   );

   mdrop_rx_idle #(.CW(IDLE_W)) u_idle (
      .clk      (clk),
      .rst_n    (rst_n),
      .limit    (idle_limit),
      .tick     (idle_tick),
      .ch_valid (ch_valid),
      .active   (active),
      .hit      (idle_hit)
   );

   mdrop_rx_ring #(.NBUF(NBUF), .DEPTH(DEPTH), .DW(DW)) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .cont_mode (cont_mode),
      .store     (store),
      .boundary  (boundary),
      .tag_addr  (tag_addr),
      .tag_am    (tag_am),
      .brk_evt   (brk_evt),
      .ferr      (ch_ferr),
      .perr      (ch_perr),
      .data      (ch_data),
      .idle_hit  (idle_hit),
      .arm       (buf_arm),
      .active    (active),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .buf_empty (buf_empty),
      .buf_flags (buf_flags),
      .buf_len   (buf_len),
      .buf_close (buf_close)
   );

endmodule

// File: rtl/mdrop_rx_bufctl_chk.sv
module mdrop_rx_bufctl_chk #(
   parameter int NBUF = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic [1:0]      mode,
   input logic            cont_mode,
   input logic            ch_valid,
   input logic            ch_addr,
   input logic            ch_brk,
   input logic            ch_ferr,
   input logic            ch_perr,
   input logic            idle_tick,
   input logic [NBUF-1:0] buf_arm,
   input logic            mem_we,
   input logic [NBUF-1:0] buf_empty,
   input logic [NBUF-1:0] buf_close
);

   AST_WRITE_NEEDS_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> $past(ch_valid)); // R1

   AST_CLEAN_CLOSE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(cont_mode) && $past(buf_arm) == '0) |-> ((buf_close & buf_empty) == '0)); // R2

   AST_CLOSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_close != '0) |-> $past(ch_valid || idle_tick)); // R3

   AST_ERROR_BYTE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(ch_ferr || ch_perr)) |-> (buf_close != '0)); // R4

   AST_ERROR_CLOSE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(ch_ferr || ch_perr) && $past(buf_arm) == '0 && $countones(buf_close) == 1)
      |-> ((buf_close & buf_empty) == '0)); // R8

   AST_AUTO_ADDR_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_valid && ch_addr && !ch_brk && mode == 2'd2) |=> !mem_we); // R10

endmodule

bind mdrop_rx_bufctl mdrop_rx_bufctl_chk #(.NBUF(NBUF)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode      (mode),
   .cont_mode (cont_mode),
   .ch_valid  (ch_valid),
   .ch_addr   (ch_addr),
   .ch_brk    (ch_brk),
   .ch_ferr   (ch_ferr),
   .ch_perr   (ch_perr),
   .idle_tick (idle_tick),
   .buf_arm   (buf_arm),
   .mem_we    (mem_we),
   .buf_empty (buf_empty),
   .buf_close (buf_close)
);

// File: tb/test_mdrop_rx_bufctl.sv
module test_mdrop_rx_bufctl;

   localparam int F_OV = 1, F_PR = 2, F_FR = 4, F_BRK = 8, F_AM = 16, F_IDLE = 32, F_ADDR = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mode = 2'd0;
   logic        cont_mode = 1'b0;
   logic [7:0]  addr_a = 8'h31, addr_b = 8'h32;
   logic [15:0] idle_limit = 16'd3;
   logic        ch_valid = 1'b0, ch_addr = 1'b0, ch_brk = 1'b0, ch_ferr = 1'b0, ch_perr = 1'b0;
   logic [7:0]  ch_data = 8'h00;
   logic        idle_tick = 1'b0;
   logic [3:0]  buf_arm = 4'h0;
   logic        mem_we;
   logic [5:0]  mem_addr;
   logic [7:0]  mem_wdata;
   logic [3:0]  buf_empty, buf_close;
   logic [27:0] buf_flags;
   logic [19:0] buf_len;

   int   checks = 0, errors = 0;
   bit   done = 1'b0;
   logic [13:0] expq [$];

   always #5 clk = ~clk;

   mdrop_rx_bufctl i_mdrop_rx_bufctl (
      .clk(clk), .rst_n(rst_n), .mode(mode), .cont_mode(cont_mode),
      .addr_a(addr_a), .addr_b(addr_b), .idle_limit(idle_limit),
      .ch_valid(ch_valid), .ch_data(ch_data), .ch_addr(ch_addr), .ch_brk(ch_brk),
      .ch_ferr(ch_ferr), .ch_perr(ch_perr), .idle_tick(idle_tick), .buf_arm(buf_arm),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .buf_empty(buf_empty), .buf_flags(buf_flags), .buf_len(buf_len), .buf_close(buf_close)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int fl(input int i);
      return int'(buf_flags[i*7 +: 7]);
   endfunction

   function automatic int ln(input int i);
      return int'(buf_len[i*5 +: 5]);
   endfunction

   // monitor: every memory write must match the next expected item (R1)
   always @(negedge clk) begin
      if (rst_n && mem_we) begin
         checks++;
         if (expq.size() == 0) begin
            errors++;
            $display("FAIL R1 unexpected write: actual=%0d/%0d expected=none", mem_addr, mem_wdata);
         end else begin
            logic [13:0] e;
            e = expq.pop_front();
            if ({mem_addr, mem_wdata} !== e) begin
               errors++;
               $display("FAIL R1 write: actual=%0d/%0d expected=%0d/%0d",
                        mem_addr, mem_wdata, e[13:8], e[7:0]);
            end
         end
      end
   end

   task automatic send(input logic [7:0] d, input bit a, input bit b, input bit f,
                       input bit p, input bit exp_w, input int exp_addr);
      if (exp_w) expq.push_back({6'(exp_addr), d});
      ch_valid = 1'b1; ch_data = d; ch_addr = a; ch_brk = b; ch_ferr = f; ch_perr = p;
      @(posedge clk);
      @(negedge clk);
      ch_valid = 1'b0; ch_addr = 1'b0; ch_brk = 1'b0; ch_ferr = 1'b0; ch_perr = 1'b0;
   endtask

   task automatic data(input logic [7:0] d, input int exp_addr);
      send(d, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, exp_addr);
   endtask

   task automatic drop(input logic [7:0] d);
      send(d, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0);
   endtask

   task automatic tick();
      idle_tick = 1'b1;
      @(posedge clk);
      @(negedge clk);
      idle_tick = 1'b0;
   endtask

   task automatic arm(input logic [3:0] m);
      buf_arm = m;
      @(posedge clk);
      @(negedge clk);
      buf_arm = 4'h0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R13 reset state
      chk("R13", "empty", buf_empty, 0);
      chk("R13", "flags", int'(buf_flags), 0);
      chk("R13", "len", int'(buf_len), 0);
      chk("R13", "close", buf_close, 0);
      chk("R13", "we", mem_we, 0);
      arm(4'hF);
      chk("R12", "empty after arm", buf_empty, 15);

      // R1/R3 plain mode with idle counting
      data(8'h11, 0);
      tick(); tick();
      data(8'h22, 1);
      tick(); tick();
      chk("R3", "no early idle close", buf_close, 0);
      chk("R3", "still owned", buf_empty, 15);
      data(8'h33, 2);
      tick(); tick(); tick();
      chk("R3", "idle close pulse", buf_close, 1);
      chk("R3", "idle flag", fl(0), F_IDLE);
      chk("R3", "idle len", ln(0), 3);
      chk("R3", "idle released", buf_empty, 14);

      // R5 parity error
      data(8'h44, 16);
      send(8'h55, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 17);
      chk("R5", "pr close", buf_close, 2);
      chk("R5", "pr flag", fl(1), F_PR);
      chk("R5", "pr len", ln(1), 2);
      // R4 framing error, next byte lands in buffer 2
      data(8'h66, 32);
      send(8'h77, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 33);
      chk("R4", "fr close", buf_close, 4);
      chk("R4", "fr flag", fl(2), F_FR);
      chk("R4", "fr len", ln(2), 2);
      chk("R4", "empty", buf_empty, 8);

      // R2 full buffer
      for (int k = 0; k < 16; k++) data(8'h80 + 8'(k), 48 + k);
      chk("R2", "full close", buf_close, 8);
      chk("R2", "full flags", fl(3), 0);
      chk("R2", "full len", ln(3), 16);
      chk("R2", "full released", buf_empty, 0);

      // R7 overrun
      drop(8'h99);
      chk("R7", "ov flag", fl(3), F_OV);
      chk("R7", "no close", buf_close, 0);

      // R12 re-arm
      arm(4'hF);
      chk("R12", "empty", buf_empty, 15);
      chk("R12", "flags cleared", fl(3), 0);
      chk("R12", "len cleared", ln(3), 0);

      // R6 break
      data(8'h10, 0);
      send(8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 0);
      chk("R6", "brk close", buf_close, 1);
      chk("R6", "brk flag", fl(0), F_BRK);
      chk("R6", "brk len", ln(0), 1);
      send(8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 0);
      chk("R6", "idle brk no close", buf_close, 0);
      chk("R6", "idle brk flags", fl(1), 0);
      chk("R6", "idle brk empty", buf_empty, 14);

      // R8 continuous mode
      cont_mode = 1'b1;
      for (int k = 0; k < 16; k++) data(8'hC0 + 8'(k), 16 + k);
      chk("R8", "cont close", buf_close, 2);
      chk("R8", "cont kept", buf_empty, 14);
      chk("R8", "cont len", ln(1), 16);
      send(8'h01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32);
      chk("R8", "cont err released", buf_empty, 10);
      chk("R8", "cont err flag", fl(2), F_PR);
      cont_mode = 1'b0;
      arm(4'hF);

      // R9 manual multidrop
      mode = 2'd1;
      send(8'hA5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 48);
      chk("R9", "addr flag", fl(3), F_ADDR);
      data(8'h01, 49);
      send(8'h5A, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 0);
      chk("R9", "boundary close", buf_close, 8);
      chk("R9", "closed len", ln(3), 2);
      chk("R9", "new addr flag", fl(0), F_ADDR);
      chk("R9", "empty", buf_empty, 7);
      data(8'h02, 1);

      // R10/R11 automatic multidrop
      mode = 2'd2;
      drop(8'h40);
      chk("R10", "no accept close", buf_close, 0);
      send(8'h77, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0);
      chk("R10", "unmatched addr closes", buf_close, 1);
      chk("R10", "closed len", ln(0), 2);
      drop(8'h41);
      send(8'h32, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0);
      chk("R10", "match no close", buf_close, 0);
      data(8'h42, 16);
      chk("R11", "match b flags", fl(1), F_ADDR);
      data(8'h43, 17);
      send(8'h31, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0);
      chk("R10", "addr closes", buf_close, 2);
      data(8'h44, 32);
      chk("R11", "match a flags", fl(2), F_ADDR + F_AM);
      send(8'h30, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0);
      chk("R10", "addr closes 2", buf_close, 4);
      drop(8'h45);

      repeat (3) @(negedge clk);
      chk("R1", "pending writes", expq.size(), 0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule